// File: doc/BRIEF.md
# Programmable-Polarity Chip Enable Decoder

This block turns three chip enable inputs into the select signals of a pipelined synchronous memory. One enable is always active-low. Each of the other two has its active level fixed by a static strap input. The enables are captured only on cycles where a new external address is loaded. Between loads, the captured selection is held, so every beat of a burst sees the same select state.

The block drives three outputs. The core select goes to the array. The data output enable and the echo clock enable are delayed by the same number of cycles as read data. Only the two strap-programmed enables can switch the echo clocks off. Deselecting through the fixed active-low enable alone leaves the echo clocks running.

Because each of the two programmable enables can be set to either level, four copies can share one memory bus without external logic. Give each copy a different strap code and drive its two programmable enables from two address bits. Each address pair then selects exactly one copy.

Top module: `ce_select_top`

## Requirements
- R1: While `rst` is high at a clock edge, `core_sel`, `dout_en` and `echo_en` are all 0 after that edge.
- R2: `e2` counts as active when it equals `ep2`: active-high when `ep2` = 1, active-low when `ep2` = 0. A load edge with `e2` inactive leaves `core_sel` at 0 after the edge.
- R3: `e3` counts as active when it equals `ep3`, with the same polarity rule as R2. A load edge with `e3` inactive leaves `core_sel` at 0 after the edge.
- R4: `e1_n` is active-low. At a load edge (`load` = 1), `core_sel` becomes 1 after the edge only if all three enables are active.
- R5: At an edge with `load` = 0, the enable and strap inputs are ignored and `core_sel` keeps its value.
- R6: `dout_en` equals `core_sel` delayed by `OUT_LAT` clock cycles (default 1).
- R7: The echo clock state is captured at each load edge as "`e2` active and `e3` active", regardless of `e1_n`. `echo_en` shows that state delayed by `OUT_LAT` cycles, the same delay as `dout_en`.
- R8: Take four instances with strap codes {`ep2`,`ep3`} = 00, 01, 10, 11. Drive `e2` from address bit 1 and `e3` from address bit 0, and load with `e1_n` = 0. Exactly one instance then has `core_sel` = 1: the one whose strap code equals the address pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | New external address loaded this edge |
| e1_n | input | 1 | Fixed active-low chip enable |
| e2 | input | 1 | Programmable-polarity chip enable |
| e3 | input | 1 | Programmable-polarity chip enable |
| ep2 | input | 1 | Static strap: active level of `e2` |
| ep3 | input | 1 | Static strap: active level of `e3` |
| core_sel | output | 1 | Registered array select |
| dout_en | output | 1 | Data output enable, delayed like read data |
| echo_en | output | 1 | Echo clock output enable, delayed like read data |

## Verification
The assertions are evaluated on every clock. They cover the reset state and blocking by any inactive enable at a load edge. They also cover holding the select on non-load edges and the fixed delay from `core_sel` to `dout_en`. A final one checks that the data enable never runs without the echo enable.

Some behaviour needs the bench's scenarios. These are the echo clocks staying on after a deselect through `e1_n` alone, the exact delay of `echo_en`, and the one-of-four decode across four differently strapped instances. The bench's reference model shows them by sweeping every address pair with `e1_n` both active and inactive, and by running bursts and a reset in mid-stream.

// File: rtl/ce_sel_pkg.sv
package ce_sel_pkg;

  // Number of strap-programmed enables.
  localparam int NPROG = 2;

  // Captured selection state.
  typedef struct packed {
    logic echo;   // programmable enables all active
    logic core;   // every enable active
  } sel_state_t;

  localparam int STATE_W = $bits(sel_state_t);

  function automatic sel_state_t decode_sel(input logic e1_n,
                                            input logic [NPROG-1:0] act);
    sel_state_t s;
    s.echo = &act;
    s.core = (~e1_n) & (&act);
    return s;
  endfunction

endpackage

// File: rtl/ce_polarity_map.sv
module ce_polarity_map #(
  parameter int N = 2
) (
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] strap_i,
  output logic [N-1:0] act_o
);

  // An enable is active when its level matches its strap.
  for (genvar g = 0; g < N; g++) begin : g_pol
    assign act_o[g] = ~(en_i[g] ^ strap_i[g]);
  end

endmodule

// File: rtl/ce_sel_capture.sv
module ce_sel_capture
  import ce_sel_pkg::*;
#(
  parameter int N = NPROG
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         e1_n_i,
  input  logic [N-1:0] act_i,
  output sel_state_t   state_o
);

  sel_state_t state_q;

  // Capture on load edges only; hold through burst cycles.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
    end else if (load_i) begin
      state_q <= decode_sel(e1_n_i, act_i);
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/ce_out_pipe.sv
module ce_out_pipe #(
  parameter int DEPTH = 1,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  if (DEPTH == 0) begin : g_pass
    assign q_o = d_i;
  end else begin : g_regs
    logic [W-1:0] stg_q [DEPTH];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
      end else begin
        stg_q[0] <= d_i;
        for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
      end
    end

    assign q_o = stg_q[DEPTH-1];
  end

endmodule

// File: rtl/ce_select_top.sv
module ce_select_top
  import ce_sel_pkg::*;
#(
  parameter int OUT_LAT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic e1_n,
  input  logic e2,
  input  logic e3,
  input  logic ep2,
  input  logic ep3,
  output logic core_sel,
  output logic dout_en,
  output logic echo_en
);

  logic [NPROG-1:0] prog_en;
  logic [NPROG-1:0] prog_strap;
  logic [NPROG-1:0] prog_act;
  sel_state_t       st;
  logic [STATE_W-1:0] pipe_out;

  assign prog_en    = {e3, e2};
  assign prog_strap = {ep3, ep2};

  ce_polarity_map #(.N(NPROG)) u_pol (
    .en_i    (prog_en),
    .strap_i (prog_strap),
    .act_o   (prog_act)
  );

  ce_sel_capture #(.N(NPROG)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .e1_n_i  (e1_n),
    .act_i   (prog_act),
    .state_o (st)
  );

  // Both driver enables travel with the read data.
  ce_out_pipe #(.DEPTH(OUT_LAT), .W(STATE_W)) u_pipe (
    .clk (clk),
    .rst (rst),
    .d_i (st),
    .q_o (pipe_out)
  );

  assign core_sel = st.core;
  assign dout_en  = pipe_out[0];
  assign echo_en  = pipe_out[1];

endmodule

// File: rtl/ce_select_chk.sv
module ce_select_chk #(
  parameter int OUT_LAT = 1
) (
  input logic clk,
  input logic rst,
  input logic load,
  input logic e1_n,
  input logic e2,
  input logic e3,
  input logic ep2,
  input logic ep3,
  input logic core_sel,
  input logic dout_en,
  input logic echo_en
);

  localparam int HD = (OUT_LAT < 1) ? 1 : OUT_LAT;

  // History of core_sel, used to check the output delay window.
  logic hist_q [HD];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HD; i++) hist_q[i] <= 1'b0;
    end else begin
      hist_q[0] <= core_sel;
      for (int i = 1; i < HD; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!core_sel && !dout_en && !echo_en));

  p_pol_e2_r2: assert property (@(posedge clk) disable iff (rst)
    (load && (e2 != ep2)) |=> !core_sel);

  p_pol_e3_r3: assert property (@(posedge clk) disable iff (rst)
    (load && (e3 != ep3)) |=> !core_sel);

  p_e1_block_r4: assert property (@(posedge clk) disable iff (rst)
    (load && e1_n) |=> !core_sel);

  p_all_active_r4: assert property (@(posedge clk) disable iff (rst)
    (load && !e1_n && (e2 == ep2) && (e3 == ep3)) |=> core_sel);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(core_sel));

  if (OUT_LAT >= 1) begin : g_lat
    p_dout_delay_r6: assert property (@(posedge clk) disable iff (rst)
      dout_en == hist_q[HD-1]);
  end

  p_echo_with_data_r7: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> echo_en);

endmodule

bind ce_select_top ce_select_chk #(.OUT_LAT(OUT_LAT)) u_ce_select_chk (
  .clk      (clk),
  .rst      (rst),
  .load     (load),
  .e1_n     (e1_n),
  .e2       (e2),
  .e3       (e3),
  .ep2      (ep2),
  .ep3      (ep3),
  .core_sel (core_sel),
  .dout_en  (dout_en),
  .echo_en  (echo_en)
);

// File: tb/test_ce_select_top.sv
module test_ce_select_top;

  localparam int LAT = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic e1_n = 1'b1;
  logic [1:0] addr = 2'b00;

  logic [3:0] core_sel, dout_en, echo_en;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  // Four banks, strap code {ep2,ep3} = bank index.
  for (genvar b = 0; b < 4; b++) begin : g_bank
    ce_select_top #(.OUT_LAT(LAT)) i_ce_select_top (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .e1_n     (e1_n),
      .e2       (addr[1]),
      .e3       (addr[0]),
      .ep2      (b[1]),
      .ep3      (b[0]),
      .core_sel (core_sel[b]),
      .dout_en  (dout_en[b]),
      .echo_en  (echo_en[b])
    );
  end

  // Reference model.
  bit m_sel [4];
  bit m_echo [4];
  bit h_d [4][LAT];
  bit h_e [4][LAT];
  bit m_e1ok = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    for (int b = 0; b < 4; b++) begin
      if (rst) begin
        m_sel[b] = 1'b0;
        m_echo[b] = 1'b0;
        for (int k = 0; k < LAT; k++) begin
          h_d[b][k] = 1'b0;
          h_e[b][k] = 1'b0;
        end
      end else begin
        for (int k = LAT - 1; k > 0; k--) begin
          h_d[b][k] = h_d[b][k-1];
          h_e[b][k] = h_e[b][k-1];
        end
        h_d[b][0] = m_sel[b];
        h_e[b][0] = m_echo[b];
        if (load) begin
          m_echo[b] = (addr[1] == b[1]) && (addr[0] == b[0]);
          m_sel[b]  = m_echo[b] && (e1_n == 1'b0);
        end
      end
    end
    if (rst) m_e1ok = 1'b0;
    else if (load) m_e1ok = (e1_n == 1'b0);
    #2;
    for (int b = 0; b < 4; b++) begin
      check(core_sel[b] == m_sel[b], rst ? "R1 core_sel" : "R2/R3/R4/R5 core_sel",
            core_sel[b], m_sel[b]);
      check(dout_en[b] == h_d[b][LAT-1], "R6 dout_en", dout_en[b], h_d[b][LAT-1]);
      check(echo_en[b] == h_e[b][LAT-1], "R7 echo_en", echo_en[b], h_e[b][LAT-1]);
    end
    check($countones(core_sel) == (m_e1ok ? 1 : 0), "R8 one-of-four select",
          $countones(core_sel), m_e1ok ? 1 : 0);
  end

  // Watchdog.
  always @(posedge clk) begin
    if (cyc > 5000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
      finish_run();
    end
  end

  task automatic step(input bit ld, input bit e1, input logic [1:0] a);
    @(negedge clk);
    load = ld;
    e1_n = e1;
    addr = a;
  endtask

  initial begin
    // R1: reset with load activity present.
    step(1'b1, 1'b0, 2'b11);
    step(1'b1, 1'b0, 2'b00);
    step(1'b0, 1'b0, 2'b00);
    @(negedge clk);
    rst = 1'b0;
    // R2, R3, R4, R8: sweep address pairs with e1_n active and inactive.
    for (int e = 0; e < 2; e++) begin
      for (int a = 0; a < 4; a++) begin
        step(1'b1, e[0], a[1:0]);
        // R5: inputs wander while no load.
        step(1'b0, ~e[0], ~a[1:0]);
        step(1'b0, 1'b1, a[1:0] ^ 2'b01);
      end
    end
    // R7: deselect through e1_n only keeps echo running.
    step(1'b1, 1'b0, 2'b10);
    step(1'b1, 1'b1, 2'b10);
    step(1'b0, 1'b0, 2'b01);
    step(1'b0, 1'b0, 2'b01);
    // Burst: load then hold for four beats.
    step(1'b1, 1'b0, 2'b01);
    for (int k = 0; k < 4; k++) step(1'b0, k[0], k[1:0]);
    // Back-to-back loads.
    for (int a = 0; a < 4; a++) step(1'b1, 1'b0, 2'(3 - a));
    // R1: reset in mid-stream.
    @(negedge clk);
    rst = 1'b1;
    step(1'b1, 1'b0, 2'b11);
    @(negedge clk);
    rst = 1'b0;
    step(1'b1, 1'b0, 2'b00);
    step(1'b0, 1'b0, 2'b00);
    step(1'b0, 1'b0, 2'b00);
    @(negedge clk);
    finish_run();
  end

endmodule